// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Write-One-to-Clear Status

This block gathers up to fifteen interrupt lines. Each line has a two-bit priority code. A rising edge on a line marks that line as pending. The block compares all pending lines whose code is nonzero and offers the winner to the processor core as a request, together with the line index and the line's level. The core takes the request with an acknowledge pulse. That pulse clears the winner's pending bit and raises the level in service to the winner's level. A later return pulse restores the level that was in service before.

Software reaches the block through one write port and one combinational read port. Each port has a register select. Selects 0 and 1 reach the two priority registers. Select 2 reaches the pending-status register, whose bits are cleared by writing ones. Select 3 reads as zero and ignores writes. A software polling loop can clear one line by writing a one to that line's bit and zeros to every other bit.

Nesting is managed by a small state machine with two states. In ST_BASE nothing is in service. In ST_NESTED one or more acknowledged levels are stacked. The state machine has four transitions:
- PUSH_FIRST goes from ST_BASE to ST_NESTED.
- PUSH_MORE goes from ST_NESTED to ST_NESTED.
- POP_INNER goes from ST_NESTED to ST_NESTED while deeper entries remain.
- POP_LAST goes from ST_NESTED to ST_BASE.

A return in ST_BASE is the IGNORE_POP self-loop.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Every line has a two-bit code: 00 disabled, 01 level 1 (lowest), 10 level 2, 11 level 3 (highest). Select 0 holds line k (k = 0..9) at bits 2k+1:2k. Select 1 holds line k (k = 10..14) at bits 2(k-10)+1:2(k-10). Codes are written and read back through these positions.
- R2: Reset clears all codes, all pending bits, the level in service (to 0) and the request.
- R3: A rising edge on a line sets that line's pending bit. A line held high does not set the bit again after it has been cleared.
- R4: Status (select 2) bit k reads 1 when line k is pending. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Bits 19:15 read zero and ignore writes.
- R5: If a rising edge and a clear of the same bit happen in the same cycle, the bit ends up set.
- R6: The winner is the pending, enabled line with the highest level. Among lines at the same level, the lowest index wins. irq_idx and irq_lvl show the winner, and show 0 when there is none.
- R7: irq_req is high only when a winner exists and its level is strictly above the level in service.
- R8: An acknowledge while irq_req is high clears the winner's pending bit and makes the winner's level the level in service. An acknowledge while irq_req is low has no effect.
- R9: A return restores the level that was in service before the latest accepted acknowledge. A return at base level is ignored. A return in the same cycle as an accepted acknowledge is ignored.
- R10: A pending bit is kept while its line is disabled. The line competes as soon as a nonzero code is written for it.
- R11: Bits 19:10 of select 1 read zero and ignore writes. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 15 | Interrupt lines, rising-edge captured |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write select: 0/1 priority, 2 status, 3 none |
| reg_wr_data | input | 20 | Write data |
| reg_rd_sel | input | 2 | Read select, same encoding |
| reg_rd_data | output | 20 | Read data, combinational |
| irq_req | output | 1 | Request to the core |
| irq_idx | output | 4 | Winning line index |
| irq_lvl | output | 2 | Winning line level |
| irq_ack | input | 1 | Core acknowledge pulse |
| irq_ret | input | 1 | Core return-from-service pulse |
| cur_lvl | output | 2 | Level currently in service |

## Verification
The cycle-level assertions check several properties on every clock:
- every edge lands in the pending bits and no bit is set without an edge;
- write-one-to-clear takes effect;
- no enabled pending line outranks the reported winner, and ties go to the lower index;
- an accepted acknowledge clears the winner and loads its level;
- the level stack never overflows, and base state means level 0.

Some behaviours can only be shown by the bench's scenarios. These are the exact register bit positions, reserved-bit masking and set-versus-clear collisions. They also include ignored acknowledges, returns at base or with an acknowledge, and retention of pending bits while a line is disabled. Restoring earlier levels across several nesting steps, and the full clearing done by reset, are also covered only by the scenarios.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Nesting state of the level-in-service stack
    typedef enum logic [0:0] {
        ST_BASE   = 1'b0,
        ST_NESTED = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
    parameter int NUM_SRC = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] sw_clr_i,
    input  logic [NUM_SRC-1:0] ack_clr_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] edge_o
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_d;
    logic [NUM_SRC-1:0] edge_w;

    assign edge_w = src_i & ~src_q;
    // a fresh edge overrides any clear in the same cycle
    assign pend_d = (pend_q & ~sw_clr_i & ~ack_clr_i) | edge_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;
    assign edge_o = edge_w;

    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_w) |=> ((pend_q & $past(edge_w)) == $past(edge_w)));

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(edge_w)) == '0));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr_i & ~edge_w)) |=> ((pend_q & $past(sw_clr_i & ~edge_w)) == '0));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = 15,
    parameter int LVL_W   = 2,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0]       pend_i,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
    output logic                     win_valid_o,
    output logic [IDX_W-1:0]         win_idx_o,
    output logic [LVL_W-1:0]         win_lvl_o
);

    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_lvl_o   = '0;
        // scan from the top index down so that ties settle on the lowest index
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (lvl_i[i*LVL_W +: LVL_W] != '0) &&
                (lvl_i[i*LVL_W +: LVL_W] >= win_lvl_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_lvl_o   = lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_pkg::*;
#(
    parameter int LVL_W = 2,
    parameter int DEPTH = 3,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [LVL_W-1:0] cur_lvl_o
);

    lvl_state_e       state_q, state_d;
    logic             do_push, do_pop;
    logic [LVL_W-1:0] cur_q;
    logic [DW-1:0]    depth_q;
    logic [LVL_W-1:0] stk_q [DEPTH];
    logic [LVL_W-1:0] pop_val;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BASE;
        else        state_q <= state_d;
    end

    // transitions; a push outranks a pop in the same cycle
    always_comb begin
        state_d = state_q;
        do_push = 1'b0;
        do_pop  = 1'b0;
        unique case (state_q)
            ST_BASE: begin
                if (push_i) begin          // PUSH_FIRST
                    do_push = 1'b1;
                    state_d = ST_NESTED;
                end                        // IGNORE_POP otherwise
            end
            ST_NESTED: begin
                if (push_i) begin          // PUSH_MORE
                    do_push = 1'b1;
                end else if (pop_i) begin
                    do_pop = 1'b1;
                    if (depth_q == DW'(1)) state_d = ST_BASE;   // POP_LAST
                end                                             // POP_INNER
            end
            default: state_d = ST_BASE;
        endcase
    end

    always_comb begin
        pop_val = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (depth_q == DW'(e + 1)) pop_val = stk_q[e];
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              stk_q[e] <= '0;
            else if (do_push && depth_q == DW'(e))   stk_q[e] <= cur_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            depth_q <= '0;
        end else if (do_push) begin
            cur_q   <= push_lvl_i;
            depth_q <= depth_q + DW'(1);
        end else if (do_pop) begin
            cur_q   <= pop_val;
            depth_q <= depth_q - DW'(1);
        end
    end

    // outputs
    always_comb begin
        cur_lvl_o = cur_q;
    end

    assert_push_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (cur_q == $past(push_lvl_i)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (depth_q < DW'(DEPTH)));

    assert_base_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BASE) |-> (cur_q == '0 && depth_q == '0));

    assert_pop_at_base_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BASE && pop_i && !push_i) |=> (cur_q == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NUM_SRC   = 15,
    parameter int LVL_W     = 2,
    parameter int REG_W     = 20,
    localparam int FIELDS   = REG_W / LVL_W,
    localparam int CTL_REGS = (NUM_SRC + FIELDS - 1) / FIELDS,
    localparam int STAT_SEL = CTL_REGS,
    localparam int SEL_W    = $clog2(CTL_REGS + 1),
    localparam int IDX_W    = $clog2(NUM_SRC),
    localparam int DEPTH    = (2 ** LVL_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_wr_en,
    input  logic [SEL_W-1:0]   reg_wr_sel,
    input  logic [REG_W-1:0]   reg_wr_data,
    input  logic [SEL_W-1:0]   reg_rd_sel,
    output logic [REG_W-1:0]   reg_rd_data,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx,
    output logic [LVL_W-1:0]   irq_lvl,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic [LVL_W-1:0]   cur_lvl
);

    logic [LVL_W-1:0]         ctl_q [NUM_SRC];
    logic [NUM_SRC*LVL_W-1:0] lvl_flat;
    logic [NUM_SRC-1:0]       pend;
    logic [NUM_SRC-1:0]       src_edge;
    logic [NUM_SRC-1:0]       sw_clr;
    logic [NUM_SRC-1:0]       ack_clr;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_idx;
    logic [LVL_W-1:0]         win_lvl;
    logic                     ack_take;

    // priority code storage, one field per line
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_ctl
        localparam int RG  = k / FIELDS;
        localparam int OFF = (k % FIELDS) * LVL_W;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctl_q[k] <= '0;
            else if (reg_wr_en && reg_wr_sel == SEL_W'(RG))
                ctl_q[k] <= reg_wr_data[OFF +: LVL_W];
        end
        assign lvl_flat[k*LVL_W +: LVL_W] = ctl_q[k];
    end

    assign sw_clr   = (reg_wr_en && reg_wr_sel == SEL_W'(STAT_SEL)) ?
                      reg_wr_data[NUM_SRC-1:0] : '0;
    assign ack_take = irq_ack && irq_req;
    assign ack_clr  = ack_take ? (NUM_SRC'(1) << win_idx) : '0;

    irq_pend_capture #(
        .NUM_SRC (NUM_SRC)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .sw_clr_i  (sw_clr),
        .ack_clr_i (ack_clr),
        .pend_o    (pend),
        .edge_o    (src_edge)
    );

    irq_arbiter #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W)
    ) u_arb (
        .pend_i      (pend),
        .lvl_i       (lvl_flat),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_lvl_o   (win_lvl)
    );

    irq_level_stack #(
        .LVL_W (LVL_W),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack_take),
        .push_lvl_i (win_lvl),
        .pop_i      (irq_ret),
        .cur_lvl_o  (cur_lvl)
    );

    assign irq_req = win_valid && (win_lvl > cur_lvl);
    assign irq_idx = win_idx;
    assign irq_lvl = win_lvl;

    // read mux: priority registers by position, status by line index
    always_comb begin
        reg_rd_data = '0;
        if (reg_rd_sel == SEL_W'(STAT_SEL)) begin
            reg_rd_data[NUM_SRC-1:0] = pend;
        end else begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (reg_rd_sel == SEL_W'(k / FIELDS))
                    reg_rd_data[(k % FIELDS) * LVL_W +: LVL_W] = ctl_q[k];
            end
        end
    end

    // no enabled pending line may outrank the winner; ties go low
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        assert_no_better_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[k] && ctl_q[k] != '0) |->
            (win_valid && (ctl_q[k] < win_lvl ||
                           (ctl_q[k] == win_lvl && IDX_W'(k) >= win_idx))));
    end

    assert_req_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend[irq_idx] && ctl_q[irq_idx] != '0 && irq_lvl > cur_lvl));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !src_edge[irq_idx]) |=> !pend[$past(irq_idx)]);

    assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !irq_ret) |=> $stable(cur_lvl));

    if (NUM_SRC < REG_W) begin : g_rsvd
        assert_status_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd_sel == SEL_W'(STAT_SEL)) |-> (reg_rd_data[REG_W-1:NUM_SRC] == '0));
    end

endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

    localparam int NSRC = 15;
    localparam int VW   = 54;
    localparam int NVEC = 24;

    // op codes
    localparam logic [2:0] OP_NOP = 3'd0, OP_WR0 = 3'd1, OP_WR1 = 3'd2, OP_WRS = 3'd3,
                           OP_PLS = 3'd4, OP_ACK = 3'd5, OP_RET = 3'd6, OP_AR  = 3'd7;

    // {op, arg, rsel, req, idx, lvl, cur, rd}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {OP_NOP, 20'h00000, 2'd2, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00000},
        {OP_PLS, 20'h00005, 2'd2, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00005}, // R10 disabled kept
        {OP_WR0, 20'h00010, 2'd0, 1'b1, 4'd2,  2'd1, 2'd0, 20'h00010},
        {OP_WR0, 20'h00013, 2'd0, 1'b1, 4'd0,  2'd3, 2'd0, 20'h00013},
        {OP_ACK, 20'h00000, 2'd2, 1'b0, 4'd2,  2'd1, 2'd3, 20'h00004},
        {OP_PLS, 20'h00008, 2'd2, 1'b0, 4'd2,  2'd1, 2'd3, 20'h0000C},
        {OP_WR0, 20'h000D3, 2'd0, 1'b0, 4'd3,  2'd3, 2'd3, 20'h000D3}, // R7 equal level
        {OP_RET, 20'h00000, 2'd2, 1'b1, 4'd3,  2'd3, 2'd0, 20'h0000C},
        {OP_WRS, 20'h00008, 2'd2, 1'b1, 4'd2,  2'd1, 2'd0, 20'h00004}, // poll clear
        {OP_WR1, 20'h00020, 2'd1, 1'b1, 4'd2,  2'd1, 2'd0, 20'h00020},
        {OP_PLS, 20'h01400, 2'd2, 1'b1, 4'd12, 2'd2, 2'd0, 20'h01404},
        {OP_ACK, 20'h00000, 2'd2, 1'b0, 4'd2,  2'd1, 2'd2, 20'h00404},
        {OP_WR0, 20'h00033, 2'd0, 1'b1, 4'd2,  2'd3, 2'd2, 20'h00033},
        {OP_ACK, 20'h00000, 2'd2, 1'b0, 4'd0,  2'd0, 2'd3, 20'h00400},
        {OP_RET, 20'h00000, 2'd2, 1'b0, 4'd0,  2'd0, 2'd2, 20'h00400},
        {OP_RET, 20'h00000, 2'd2, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00400},
        {OP_RET, 20'h00000, 2'd2, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00400}, // R9 base ignored
        {OP_WRS, 20'hFFFFF, 2'd2, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00000},
        {OP_WR1, 20'hFFFFF, 2'd1, 1'b0, 4'd0,  2'd0, 2'd0, 20'h003FF}, // R11
        {OP_WR0, 20'h00104, 2'd0, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00104},
        {OP_PLS, 20'h00012, 2'd2, 1'b1, 4'd1,  2'd1, 2'd0, 20'h00012}, // tie
        {OP_WR0, 20'h00000, 2'd2, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00012},
        {OP_ACK, 20'h00000, 2'd2, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00012}, // R8 ignored
        {OP_NOP, 20'h00000, 2'd3, 1'b0, 4'd0,  2'd0, 2'd0, 20'h00000}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic            reg_wr_en = 1'b0;
    logic [1:0]      reg_wr_sel = '0;
    logic [19:0]     reg_wr_data = '0;
    logic [1:0]      reg_rd_sel = '0;
    logic [19:0]     reg_rd_data;
    logic            irq_req;
    logic [3:0]      irq_idx;
    logic [1:0]      irq_lvl;
    logic            irq_ack = 1'b0;
    logic            irq_ret = 1'b0;
    logic [1:0]      cur_lvl;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_sel  (reg_wr_sel),
        .reg_wr_data (reg_wr_data),
        .reg_rd_sel  (reg_rd_sel),
        .reg_rd_data (reg_rd_data),
        .irq_req     (irq_req),
        .irq_idx     (irq_idx),
        .irq_lvl     (irq_lvl),
        .irq_ack     (irq_ack),
        .irq_ret     (irq_ret),
        .cur_lvl     (cur_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one operation spans one clock edge; inputs change on falling edges
    task automatic apply_op(input logic [2:0] op, input logic [19:0] arg);
        @(negedge clk);
        case (op)
            OP_WR0: begin reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = arg; end
            OP_WR1: begin reg_wr_en = 1'b1; reg_wr_sel = 2'd1; reg_wr_data = arg; end
            OP_WRS: begin reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = arg; end
            OP_PLS: src_i = arg[NSRC-1:0];
            OP_ACK: irq_ack = 1'b1;
            OP_RET: irq_ret = 1'b1;
            OP_AR:  begin irq_ack = 1'b1; irq_ret = 1'b1; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        irq_ack   = 1'b0;
        irq_ret   = 1'b0;
        if (op == OP_PLS) src_i = '0;
    endtask

    task automatic look(input logic [1:0] sel);
        reg_rd_sel = sel;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        look(2'd2);
        chk("R2 status after reset", reg_rd_data, 20'h0);
        chk("R2 req after reset", irq_req, 1'b0);
        look(2'd0);
        chk("R2 ctl0 after reset", reg_rd_data, 20'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            apply_op(e[53:51], e[50:31]);
            look(e[30:29]);
            chk("R7 req", irq_req, e[28]);
            chk("R6 idx", irq_idx, e[27:24]);
            chk("R6 lvl", irq_lvl, e[23:22]);
            chk("R9 cur", cur_lvl, e[21:20]);
            chk(e[30:29] == 2'd2 ? "R4 status" : "R1 ctl", reg_rd_data, e[19:0]);
        end

        // R5: edge and clear of the same bit in one cycle; status 0x12 beforehand
        @(negedge clk);
        src_i = 15'h0020;
        reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 20'h00032;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        look(2'd2);
        chk("R5 set beats clear", reg_rd_data, 20'h00020);
        // R3: held-high line does not set again once cleared
        apply_op(OP_WRS, 20'h00020);
        look(2'd2);
        chk("R3 level held no reset", reg_rd_data, 20'h0);
        apply_op(OP_NOP, 20'h0);
        look(2'd2);
        chk("R3 still clear", reg_rd_data, 20'h0);
        src_i = '0;

        // R10 and R8: disabled line kept, ack without request ignored
        apply_op(OP_PLS, 20'h00040);
        look(2'd2);
        chk("R10 disabled no req", irq_req, 1'b0);
        chk("R10 pending kept", reg_rd_data, 20'h00040);
        apply_op(OP_ACK, 20'h0);
        look(2'd2);
        chk("R8 ack ignored status", reg_rd_data, 20'h00040);
        chk("R8 ack ignored cur", cur_lvl, 2'd0);
        apply_op(OP_WR0, 20'h01000);
        look(2'd2);
        chk("R10 enabled req", irq_req, 1'b1);
        chk("R10 enabled idx", irq_idx, 4'd6);
        apply_op(OP_ACK, 20'h0);
        look(2'd2);
        chk("R8 ack clears", reg_rd_data, 20'h0);
        chk("R8 ack level", cur_lvl, 2'd1);
        apply_op(OP_RET, 20'h0);
        chk("R9 back to base", cur_lvl, 2'd0);

        // R9: ack and return together
        apply_op(OP_WR0, 20'h00002);
        apply_op(OP_PLS, 20'h00001);
        apply_op(OP_ACK, 20'h0);
        chk("R8 nest level 2", cur_lvl, 2'd2);
        apply_op(OP_WR0, 20'h00003);
        apply_op(OP_PLS, 20'h00001);
        chk("R7 higher level req", irq_req, 1'b1);
        apply_op(OP_AR, 20'h0);
        look(2'd2);
        chk("R9 ack wins over ret", cur_lvl, 2'd3);
        chk("R8 cleared on ack", reg_rd_data, 20'h0);
        apply_op(OP_RET, 20'h0);
        chk("R9 restore 2", cur_lvl, 2'd2);
        apply_op(OP_RET, 20'h0);
        chk("R9 restore 0", cur_lvl, 2'd0);

        // R11: reserved high part of select 1
        look(2'd1);
        chk("R11 ctl1 masked", reg_rd_data, 20'h003FF);

        // R2: reset in the middle of activity
        apply_op(OP_PLS, 20'h00001);
        apply_op(OP_ACK, 20'h0);
        apply_op(OP_PLS, 20'h00001);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        look(2'd0);
        chk("R2 ctl0 cleared", reg_rd_data, 20'h0);
        look(2'd1);
        chk("R2 ctl1 cleared", reg_rd_data, 20'h0);
        look(2'd2);
        chk("R2 status cleared", reg_rd_data, 20'h0);
        chk("R2 level cleared", cur_lvl, 2'd0);
        chk("R2 req low", irq_req, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule